// File: doc/BRIEF.md
# Digit-Lookup Pipelined 8x8 Unsigned Multiplier

This block forms the full 16-bit product of two 8-bit unsigned operands. It does not use a multiply operator or a shift-add array. Each operand is cut into 2-bit digits, and every pair of one digit from each operand is looked up in a small digit-product table. Each table result is then shifted by the combined weight of its two digits, and all of them are added together. With the default widths, every operand has four digits, so the grid holds sixteen lookups, and each digit weight is a power of four.

The datapath has three register stages:

1. The operands are captured.
2. The sixteen table outputs are captured.
3. The summed product is captured.

A strobe travels with each operand pair. The block accepts a new pair on every clock, and it raises its output strobe exactly three cycles after the matching input strobe. Whenever the output strobe is low, the product port reads zero. An asynchronous active-low reset empties the pipeline.

Top module: `lut_mult8`

## Requirements
- R1: When `out_valid` is high, `product` equals the exact unsigned product of the `op_a` and `op_b` values that were accepted three cycles earlier, over all 16 bits with no truncation.
- R2: `out_valid` is high in a cycle if and only if `in_valid` was high three clock edges earlier, counting only edges taken out of reset.
- R3: Operand pairs presented on consecutive cycles each give their own correct product on consecutive cycles, with no bubbles.
- R4: While `out_valid` is low, `product` reads 0.
- R5: While `rst_n` is low, `out_valid` and `product` are 0. Operand pairs accepted before a reset never produce an output strobe after that reset.
- R6: 0xFF x 0xFF gives 0xFE01. Any product with a zero operand gives 0.
- R7: The digit table gives exact products for digit values 0..3. The bench checks this through single-digit operands: 0x03 x 0x03 gives 0x0009, 0xC0 x 0xC0 gives 0x9000 (digit product 9 at weight 2^12), and 0x02 x 0x30 gives 0x0060.
- R8: Operands presented while `in_valid` is low do not raise `out_valid`, and they leave `product` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand pair valid this cycle |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| out_valid | output | 1 | Product valid this cycle |
| product | output | 16 | Unsigned product; zero when `out_valid` is low |

## Verification
The bench builds the block with its default widths: 8-bit operands and 2-bit digits, which gives four digits per operand and a 16-entry table. At these widths the whole space of 65,536 operand pairs is small enough to sweep back-to-back. Every pair therefore reaches every one of the sixteen weighted lookups in every digit combination, which covers R1 and R3 exhaustively. A seeded random phase with idle gaps and corner-biased operands follows the sweep, together with a reset taken mid-flight. This phase exercises the strobe timing, the zero-when-idle output and the dropping of in-flight pairs at reset.

// File: rtl/lut_mult8_pkg.sv
package lut_mult8_pkg;

  // Default operand and digit geometry
  localparam int unsigned OPND_W_DEF = 8;
  localparam int unsigned DIGIT_W_DEF = 2;

  // Number of pipeline register stages from operand to product
  localparam int unsigned PIPE_DEPTH = 3;

endpackage

// File: rtl/lut_mult8_digit_lut.sv
// Digit-by-digit product table: (2^DIGIT_W)^2 entries, each built by
// conditional additions at elaboration time, read by index.
module lut_mult8_digit_lut #(
  parameter int unsigned DIGIT_W = 2,
  localparam int unsigned PP_W = 2 * DIGIT_W,
  localparam int unsigned ENTRIES = 1 << (2 * DIGIT_W)
) (
  input  logic [DIGIT_W-1:0] dig_a,
  input  logic [DIGIT_W-1:0] dig_b,
  output logic [PP_W-1:0]    pp
);

  // Table index layout: {dig_b, dig_a}
  function automatic logic [PP_W-1:0] table_entry(input int unsigned idx);
    logic [DIGIT_W-1:0] x;
    logic [DIGIT_W-1:0] y;
    logic [PP_W-1:0]    acc;
    x   = idx[DIGIT_W-1:0];
    y   = idx[2*DIGIT_W-1:DIGIT_W];
    acc = '0;
    for (int k = 0; k < int'(DIGIT_W); k++) begin
      if (y[k]) acc = acc + (PP_W'(x) << k);
    end
    return acc;
  endfunction

  logic [PP_W-1:0] tbl [ENTRIES];

  for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_entry
    assign tbl[e] = table_entry(e);
  end

  assign pp = tbl[{dig_b, dig_a}];

endmodule

// File: rtl/lut_mult8_pp_array.sv
// Grid of digit lookups: one table read for every (A digit, B digit) pair.
// Flat index = i*N_DIG + j, with i the A digit and j the B digit (0 = least significant).
module lut_mult8_pp_array #(
  parameter int unsigned OPND_W = 8,
  parameter int unsigned DIGIT_W = 2,
  localparam int unsigned N_DIG = OPND_W / DIGIT_W,
  localparam int unsigned N_PP = N_DIG * N_DIG,
  localparam int unsigned PP_W = 2 * DIGIT_W
) (
  input  logic [OPND_W-1:0]          opnd_a,
  input  logic [OPND_W-1:0]          opnd_b,
  output logic [N_PP-1:0][PP_W-1:0]  pp
);

  for (genvar i = 0; i < int'(N_DIG); i++) begin : g_a
    for (genvar j = 0; j < int'(N_DIG); j++) begin : g_b
      lut_mult8_digit_lut #(
        .DIGIT_W (DIGIT_W)
      ) u_lut (
        .dig_a (opnd_a[i*DIGIT_W +: DIGIT_W]),
        .dig_b (opnd_b[j*DIGIT_W +: DIGIT_W]),
        .pp    (pp[i*N_DIG + j])
      );
    end
  end

endmodule

// File: rtl/lut_mult8_weighted_sum.sv
// Shifts each partial product by DIGIT_W*(i+j) and adds the full grid.
module lut_mult8_weighted_sum #(
  parameter int unsigned OPND_W = 8,
  parameter int unsigned DIGIT_W = 2,
  localparam int unsigned N_DIG = OPND_W / DIGIT_W,
  localparam int unsigned N_PP = N_DIG * N_DIG,
  localparam int unsigned PP_W = 2 * DIGIT_W,
  localparam int unsigned PROD_W = 2 * OPND_W
) (
  input  logic [N_PP-1:0][PP_W-1:0] pp,
  output logic [PROD_W-1:0]         sum
);

  logic [N_PP-1:0][PROD_W-1:0] term;

  for (genvar i = 0; i < int'(N_DIG); i++) begin : g_a
    for (genvar j = 0; j < int'(N_DIG); j++) begin : g_b
      assign term[i*N_DIG + j] = PROD_W'(pp[i*N_DIG + j]) << (DIGIT_W * (i + j));
    end
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < int'(N_PP); t++) begin
      sum = sum + term[t];
    end
  end

endmodule

// File: rtl/lut_mult8.sv
// Three-stage pipelined multiplier: operand capture, lookup capture, sum capture.
module lut_mult8
  import lut_mult8_pkg::*;
#(
  parameter int unsigned OPND_W = OPND_W_DEF,
  parameter int unsigned DIGIT_W = DIGIT_W_DEF,
  localparam int unsigned N_DIG = OPND_W / DIGIT_W,
  localparam int unsigned N_PP = N_DIG * N_DIG,
  localparam int unsigned PP_W = 2 * DIGIT_W,
  localparam int unsigned PROD_W = 2 * OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPND_W-1:0] op_a,
  input  logic [OPND_W-1:0] op_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] product
);

  // ---------------- stage 1: operands ----------------
  logic              s1_vld_d, s1_vld_q;
  logic [OPND_W-1:0] s1_a_d, s1_a_q;
  logic [OPND_W-1:0] s1_b_d, s1_b_q;

  always_comb begin
    s1_vld_d = in_valid;
    s1_a_d   = s1_a_q;
    s1_b_d   = s1_b_q;
    if (in_valid) begin
      s1_a_d = op_a;
      s1_b_d = op_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_a_q   <= '0;
      s1_b_q   <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_a_q   <= s1_a_d;
      s1_b_q   <= s1_b_d;
    end
  end

  // ---------------- lookups ----------------
  logic [N_PP-1:0][PP_W-1:0] pp_c;

  lut_mult8_pp_array #(
    .OPND_W  (OPND_W),
    .DIGIT_W (DIGIT_W)
  ) u_pp_array (
    .opnd_a (s1_a_q),
    .opnd_b (s1_b_q),
    .pp     (pp_c)
  );

  // ---------------- stage 2: lookup results ----------------
  logic                      s2_vld_d, s2_vld_q;
  logic [N_PP-1:0][PP_W-1:0] s2_pp_d, s2_pp_q;

  always_comb begin
    s2_vld_d = s1_vld_q;
    s2_pp_d  = s2_pp_q;
    if (s1_vld_q) begin
      s2_pp_d = pp_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q <= 1'b0;
      s2_pp_q  <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      s2_pp_q  <= s2_pp_d;
    end
  end

  // ---------------- weighted sum ----------------
  logic [PROD_W-1:0] sum_c;

  lut_mult8_weighted_sum #(
    .OPND_W  (OPND_W),
    .DIGIT_W (DIGIT_W)
  ) u_sum (
    .pp  (s2_pp_q),
    .sum (sum_c)
  );

  // ---------------- stage 3: product ----------------
  logic              s3_vld_d, s3_vld_q;
  logic [PROD_W-1:0] s3_prod_d, s3_prod_q;

  always_comb begin
    s3_vld_d  = s2_vld_q;
    s3_prod_d = '0;                 // zero whenever nothing valid arrives
    if (s2_vld_q) begin
      s3_prod_d = sum_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_vld_q  <= 1'b0;
      s3_prod_q <= '0;
    end else begin
      s3_vld_q  <= s3_vld_d;
      s3_prod_q <= s3_prod_d;
    end
  end

  assign out_valid = s3_vld_q;
  assign product   = s3_prod_q;

endmodule

// File: rtl/lut_mult8_chk.sv
module lut_mult8_chk #(
  parameter int unsigned OPND_W = 8,
  localparam int unsigned PROD_W = 2 * OPND_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OPND_W-1:0] op_a,
  input logic [OPND_W-1:0] op_b,
  input logic              out_valid,
  input logic [PROD_W-1:0] product
);

  // Edges taken since reset release, saturating at 3
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: strobe latency exactly three edges
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R1: exact full-width product
  a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid) |->
      (product == (PROD_W'($past(op_a, 3)) * PROD_W'($past(op_b, 3)))));

  // R4: idle output reads zero
  a_r4_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (product == '0));

  // R5: quiet outputs while held in reset
  a_r5_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && product == '0));

  // R5: no strobe can emerge in the first edges after reset release
  a_r5_no_stale_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> !out_valid);

endmodule

bind lut_mult8 lut_mult8_chk #(.OPND_W(OPND_W)) u_lut_mult8_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .product   (product)
);

// File: tb/lut_mult8_bench.sv
module lut_mult8_bench;

  localparam int unsigned OW = 8;
  localparam int unsigned PW = 16;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [OW-1:0] op_a;
  logic [OW-1:0] op_b;
  logic          out_valid;
  logic [PW-1:0] product;

  lut_mult8 u_lut_mult8 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  int n_vec;
  int n_bad;
  bit done;

  // Expected-result history: index 0 = driven last cycle, 2 = three cycles ago
  bit            h_v   [3];
  logic [PW-1:0] h_p   [3];
  string         h_tag [3];

  function automatic logic [PW-1:0] ref_mul(input logic [OW-1:0] a, input logic [OW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  task automatic fail_line(input string tag, input string what, input logic [PW-1:0] act,
                           input logic [PW-1:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
  endtask

  task automatic clear_hist();
    for (int k = 0; k < 3; k++) begin
      h_v[k] = 1'b0; h_p[k] = '0; h_tag[k] = "R8";
    end
  endtask

  // One cycle: check outputs at the falling edge, then drive the next inputs
  task automatic step(input bit v, input logic [OW-1:0] a, input logic [OW-1:0] b,
                      input string tag);
    @(negedge clk);
    n_vec++;
    if (out_valid !== h_v[2]) begin
      fail_line("R2", "out_valid", PW'(out_valid), PW'(h_v[2]));
    end else if (h_v[2]) begin
      if (product !== h_p[2]) fail_line(h_tag[2], "product", product, h_p[2]);
    end else if (product !== '0) begin
      fail_line((h_tag[2] == "R8") ? "R8" : "R4", "idle product", product, '0);
    end
    h_v[2] = h_v[1]; h_p[2] = h_p[1]; h_tag[2] = h_tag[1];
    h_v[1] = h_v[0]; h_p[1] = h_p[0]; h_tag[1] = h_tag[0];
    h_v[0] = v;
    h_p[0] = v ? ref_mul(a, b) : '0;
    h_tag[0] = v ? tag : "R8";
    in_valid = v; op_a = a; op_b = b;
  endtask

  task automatic mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    n_vec++;
    if (out_valid !== 1'b0 || product !== '0)
      fail_line("R5", "outputs in reset", {out_valid, product[PW-2:0]}, '0);
    in_valid = 1'b0;
    clear_hist();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;                 // released away from the rising edge
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; op_a = '0; op_b = '0;
    n_vec = 0; n_bad = 0; done = 1'b0;
    clear_hist();
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || product !== '0)            // R5 reset state
      fail_line("R5", "reset state", {out_valid, product[PW-2:0]}, '0);
    rst_n = 1'b1;

    // Directed corners
    step(1, 8'hFF, 8'hFF, "R6");
    step(1, 8'h00, 8'hA7, "R6");
    step(1, 8'h5C, 8'h00, "R6");
    step(1, 8'h03, 8'h03, "R7");
    step(1, 8'hC0, 8'hC0, "R7");
    step(1, 8'h02, 8'h30, "R7");
    step(1, 8'h80, 8'h01, "R1");
    for (int k = 0; k < 5; k++) step(0, 8'hFF, 8'hEE, "R8"); // ignored operands
    for (int k = 0; k < 3; k++) step(0, 8'h00, 8'h00, "R4");

    // Exhaustive back-to-back sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        step(1, OW'(a), OW'(b), "R3");
      end
    end
    for (int k = 0; k < 3; k++) step(0, 8'h00, 8'h00, "R4");

    // Pairs in flight, then reset: none must emerge (R5)
    step(1, 8'h12, 8'h34, "R5");
    step(1, 8'h56, 8'h78, "R5");
    mid_reset();
    for (int k = 0; k < 5; k++) step(0, 8'h00, 8'h00, "R5");

    // Seeded random phase with idle gaps and corner bias
    void'($urandom(32'd20241));
    for (int k = 0; k < 3000; k++) begin
      bit v;
      logic [OW-1:0] a, b;
      v = ($urandom % 4) != 0;
      a = OW'($urandom);
      b = OW'($urandom);
      case ($urandom % 8)
        0: a = 8'hFF;
        1: b = 8'h00;
        2: begin a = 8'hFF; b = 8'hFF; end
        default: ;
      endcase
      step(v, a, b, "R1");
    end
    for (int k = 0; k < 4; k++) step(0, 8'h00, 8'h00, "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule